// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of on-chip peripheral interrupt lines and four external request pins into a single normal interrupt output, arbitrated over eight priority levels. A separate fast interrupt output follows one dedicated external pin and nothing else. Each normal source has its own enable bit, a 3-bit priority and a 2-bit trigger mode, all held in registers reached over a simple word-addressed register bus.

To service an interrupt, software reads the vector register. The read returns the number of the winning source, marks that source as in service and pushes its level onto a priority stack. While the stack is not empty, only sources of strictly higher priority than the top entry can raise the normal output. This lets a higher level preempt one already in service. A write to the end-of-interrupt register pops the stack. A vector read with no eligible source returns a spurious code and changes nothing.

Register map (word addresses): 0 = enable bits (bit i = source i), 1 = vector (read), 2 = end of interrupt (write, data ignored), 3 = raw pending bits (read), 16+i = configuration of source i. A configuration word holds the priority in bits [2:0] and the trigger mode in bits [4:3]. The trigger mode codes are: 00 = high level, 01 = low level, 10 = rising edge, 11 = falling edge. Internal sources are numbered 0 to NUM_INT-1. External sources follow, from NUM_INT upward. Read data appears one cycle after the read strobe, qualified by a valid flag.

Top module: `vpic_top`

## Requirements
- R1: After reset, irq_o and fiq_o are low, the enable register reads 0, and a vector read returns the spurious code.
- R2: A source whose enable bit is 0 never causes irq_o to assert, even while its line is active.
- R3: A vector read returns the number of the eligible pending source with the highest priority. Among equal priorities, the lowest source number wins.
- R4: A vector read with no eligible source returns all ones (the spurious code) and leaves the in-service stack unchanged.
- R5: After a successful vector read, that priority is in service. Only sources with a strictly higher priority can assert irq_o; equal or lower levels are held off.
- R6: A write to the end-of-interrupt address pops one in-service level. Sources held off by that level can then assert irq_o again.
- R7: In a level mode, a source is pending exactly while its line is at the active level. In an edge mode, the pending state is latched on the edge and is cleared only when that source wins a vector read.
- R8: External sources honour all four trigger codes: high level, low level, rising edge and falling edge.
- R9: Internal sources ignore the polarity bit (bit 3). Code 01 acts as high level and code 11 acts as rising edge.
- R10: fiq_o equals fiq_req delayed by one clock, whatever the enables, the configuration or the stack state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_irq | input | NUM_INT | On-chip peripheral interrupt lines |
| ext_irq | input | NUM_EXT | External interrupt request pins |
| fiq_req | input | 1 | Dedicated external fast request pin |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
A corrupted in-service stack shows at the ports at once: irq_o stays low when it should rise, or rises when it should be held off. The next vector read then returns the wrong source or the spurious code. A stuck or lost edge latch shows up as irq_o staying high after the vector read that should clear it, or as irq_o never rising after a short pulse. Either shows within two clocks of the causing event. Priority or tie-break errors show on the very next vector read, one cycle after the read strobe.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int PRIO_W = 3;
  localparam int LEVELS = 1 << PRIO_W;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  typedef struct packed {
    trig_e             trig;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;

  localparam int ADDR_ENABLE  = 0;
  localparam int ADDR_VECTOR  = 1;
  localparam int ADDR_EOI     = 2;
  localparam int ADDR_PENDING = 3;
  localparam int ADDR_CFG     = 16;

  // Internal lines have no polarity choice: bit 0 is forced to zero.
  function automatic trig_e eff_trig(input trig_e t, input logic is_ext);
    return is_ext ? t : trig_e'({t[1], 1'b0});
  endfunction

  // Edge seen between the previous and the current sample.
  function automatic logic edge_hit(input trig_e t, input logic cur, input logic prev);
    return t[0] ? (~cur & prev) : (cur & ~prev);
  endfunction

  function automatic logic level_hit(input trig_e t, input logic cur);
    return t[0] ? ~cur : cur;
  endfunction
endpackage

// File: rtl/vpic_src.sv
module vpic_src
  import vpic_pkg::*;
#(
  parameter bit IS_EXT = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line,
  input  src_cfg_t cfg,
  input  logic     clr,
  output logic     pend
);
  logic  s_q, s_d, latch_q;
  trig_e mode;
  logic  edge_now;

  assign mode     = eff_trig(cfg.trig, IS_EXT);
  assign edge_now = edge_hit(mode, s_q, s_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q     <= 1'b0;
      s_d     <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      s_q     <= line;
      s_d     <= s_q;
      latch_q <= mode[1] & ((latch_q & ~clr) | edge_now);
    end
  end

  assign pend = mode[1] ? latch_q : level_hit(mode, s_q);
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
  parameter int NSRC = 8,
  parameter int PW   = 3,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]         cand,
  input  logic [NSRC-1:0][PW-1:0] prio,
  input  logic                    thr_valid,
  input  logic [PW-1:0]           thr,
  output logic                    win_valid,
  output logic [IW-1:0]           win_idx,
  output logic [PW-1:0]           win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!thr_valid || prio[i] > thr) &&
          (!win_valid || prio[i] > win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IW'(i);
        win_prio  = prio[i];
      end
    end
  end
endmodule

// File: rtl/vpic_stack.sv
module vpic_stack #(
  parameter int PW = 3,
  localparam int LEVELS  = 1 << PW,
  localparam int DEPTH_W = $clog2(LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [PW-1:0]      push_lvl,
  input  logic               pop,
  output logic [DEPTH_W-1:0] depth,
  output logic [PW-1:0]      top_lvl
);
  logic [PW-1:0]      ent [LEVELS];
  logic [DEPTH_W-1:0] top_idx;
  logic               do_push;

  assign do_push = push && (depth < DEPTH_W'(LEVELS));
  assign top_idx = depth - DEPTH_W'(1);
  assign top_lvl = (depth != '0) ? ent[top_idx[PW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (do_push) ent[depth[PW-1:0]] <= push_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  depth <= '0;
    else if (do_push)            depth <= depth + DEPTH_W'(1);
    else if (pop && depth != '0) depth <= depth - DEPTH_W'(1);
  end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int NUM_EXT = 4,
  parameter int DW      = 16,
  parameter int AW      = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_INT-1:0] int_irq,
  input  logic [NUM_EXT-1:0] ext_irq,
  input  logic               fiq_req,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_rvalid,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int NSRC    = NUM_INT + NUM_EXT;
  localparam int IW      = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int CFG_W   = $bits(src_cfg_t);
  localparam int DEPTH_W = $clog2(LEVELS + 1);

  logic [NSRC-1:0]             lines, pend, enable_q, cand, take_oh;
  src_cfg_t                    cfg_q [NSRC];
  logic [NSRC-1:0][PRIO_W-1:0] prio_v;
  logic                        win_valid;
  logic [IW-1:0]               win_idx;
  logic [PRIO_W-1:0]           win_prio, top_lvl;
  logic [DEPTH_W-1:0]          stk_depth;
  logic                        vec_rd, take_evt, spur_evt, pop_evt;
  logic [AW-1:0]               cfg_off;

  assign lines    = {ext_irq, int_irq};
  assign cand     = pend & enable_q;
  assign vec_rd   = bus_rd && (bus_addr == AW'(ADDR_VECTOR));
  assign take_evt = vec_rd && win_valid;
  assign spur_evt = vec_rd && !win_valid;
  assign pop_evt  = bus_wr && (bus_addr == AW'(ADDR_EOI));
  assign take_oh  = take_evt ? (NSRC'(1) << win_idx) : '0;
  assign cfg_off  = bus_addr - AW'(ADDR_CFG);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign prio_v[i] = cfg_q[i].prio;

    vpic_src #(.IS_EXT(i >= NUM_INT)) u_src (
      .clk  (clk),
      .rst_n(rst_n),
      .line (lines[i]),
      .cfg  (cfg_q[i]),
      .clr  (take_oh[i]),
      .pend (pend[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= '0;
      else if (bus_wr && bus_addr == AW'(ADDR_CFG + i))
        cfg_q[i] <= src_cfg_t'(bus_wdata[CFG_W-1:0]);
    end
  end

  vpic_arb #(.NSRC(NSRC), .PW(PRIO_W)) u_arb (
    .cand     (cand),
    .prio     (prio_v),
    .thr_valid(stk_depth != '0),
    .thr      (top_lvl),
    .win_valid(win_valid),
    .win_idx  (win_idx),
    .win_prio (win_prio)
  );

  vpic_stack #(.PW(PRIO_W)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (take_evt),
    .push_lvl(win_prio),
    .pop     (pop_evt),
    .depth   (stk_depth),
    .top_lvl (top_lvl)
  );

  assign irq_o = win_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q   <= '0;
      fiq_o      <= 1'b0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      fiq_o      <= fiq_req;
      bus_rvalid <= bus_rd;
      if (bus_wr && bus_addr == AW'(ADDR_ENABLE)) enable_q <= bus_wdata[NSRC-1:0];
      if (bus_rd) begin
        bus_rdata <= '0;
        if (bus_addr == AW'(ADDR_ENABLE))       bus_rdata <= DW'(enable_q);
        else if (bus_addr == AW'(ADDR_PENDING)) bus_rdata <= DW'(pend);
        else if (vec_rd)                        bus_rdata <= win_valid ? DW'(win_idx) : '1;
        else if (bus_addr >= AW'(ADDR_CFG) && cfg_off < AW'(NSRC))
          bus_rdata <= DW'(cfg_q[cfg_off[IW-1:0]]);
      end
    end
  end
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
  parameter int NSRC    = 8,
  parameter int DEPTH_W = 4,
  parameter int LEVELS  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fiq_req,
  input logic               fiq_o,
  input logic               irq_o,
  input logic               take_evt,
  input logic               spur_evt,
  input logic               pop_evt,
  input logic [NSRC-1:0]    take_oh,
  input logic [DEPTH_W-1:0] stk_depth
);
  p_fast_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> fiq_o == $past(fiq_req));

  p_take_needs_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |-> irq_o);

  p_push_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> stk_depth == $past(stk_depth) + DEPTH_W'(1));

  p_pop_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !take_evt && stk_depth != '0) |=> stk_depth == $past(stk_depth) - DEPTH_W'(1));

  p_spurious_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (spur_evt && !pop_evt) |=> $stable(stk_depth));

  p_single_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_oh));

  p_depth_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= DEPTH_W'(LEVELS));
endmodule

bind vpic_top vpic_chk #(.NSRC(NSRC), .DEPTH_W(DEPTH_W), .LEVELS(LEVELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fiq_req(fiq_req), .fiq_o(fiq_o), .irq_o(irq_o),
  .take_evt(take_evt), .spur_evt(spur_evt), .pop_evt(pop_evt),
  .take_oh(take_oh), .stk_depth(stk_depth)
);

// File: tb/tb_vpic_top.sv
module tb_vpic_top;
  localparam int NI = 4, NE = 4, DW = 16, AW = 5;
  localparam int A_EN = 0, A_VEC = 1, A_EOI = 2, A_CFG = 16;
  localparam logic [DW-1:0] SPUR = '1;

  logic clk = 0, rst_n = 0;
  logic [NI-1:0] int_irq = '0;
  logic [NE-1:0] ext_irq = '0;
  logic fiq_req = 0, bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, irq_o, fiq_o;

  int checks = 0, failures = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  vpic_top #(.NUM_INT(NI), .NUM_EXT(NE), .DW(DW), .AW(AW)) dut (.*);

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); bus_wr = 1; bus_addr = AW'(a); bus_wdata = DW'(d);
    @(negedge clk); bus_wr = 0;
  endtask

  // Driver: pushes the expected read data; the monitor compares it.
  task automatic rd(int a, logic [DW-1:0] exp, string tag);
    @(negedge clk); bus_rd = 1; bus_addr = AW'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_irq(string tag, logic exp);
    settle(); chk(tag, DW'(irq_o), DW'(exp));
  endtask

  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) chk("unexpected read", bus_rdata, '0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", DW'(irq_o), 0);
    chk("R1 fiq", DW'(fiq_o), 0);
    rd(A_EN, 0, "R1 enable");
    rd(A_VEC, SPUR, "R1 vector");

    // R7 level and R2 masking
    wr(A_CFG + 0, 2);
    wr(A_EN, 1);
    int_irq = 4'b0001;
    chk_irq("R7 level pending", 1);
    wr(A_EN, 0);
    chk_irq("R2 masked", 0);

    // R3/R5/R6 priority and nesting
    wr(A_CFG + 1, 5); wr(A_CFG + 2, 5); wr(A_CFG + 3, 6);
    int_irq = 4'b0011;
    wr(A_EN, 4'hF);
    rd(A_VEC, 1, "R3 highest");
    chk_irq("R5 lower held", 0);
    int_irq = 4'b0111;
    chk_irq("R5 equal held", 0);
    int_irq = 4'b1111;
    chk_irq("R5 higher preempts", 1);
    rd(A_VEC, 3, "R3 nested vector");
    int_irq = 4'b0111;
    chk_irq("R5 all held", 0);
    wr(A_EOI, 0);
    chk_irq("R6 one pop", 0);
    wr(A_EOI, 0);
    chk_irq("R6 stack empty", 1);
    rd(A_VEC, 1, "R3 tie lowest");
    int_irq = 4'b0000;
    wr(A_EOI, 0);
    chk_irq("R6 idle", 0);

    // R7 internal edge
    wr(A_EN, 1);
    wr(A_CFG + 0, 16 + 3);
    int_irq = 4'b0001; repeat (2) @(negedge clk); int_irq = 4'b0000;
    chk_irq("R7 edge latched", 1);
    rd(A_VEC, 0, "R7 edge vector");
    chk_irq("R7 edge cleared", 0);
    wr(A_EOI, 0);

    // R9 internal ignores polarity
    wr(A_CFG + 1, 8 + 4);
    wr(A_EN, 2);
    chk_irq("R9 low code idle", 0);
    int_irq = 4'b0010;
    chk_irq("R9 low code acts high", 1);
    int_irq = 4'b0000;
    wr(A_CFG + 0, 24 + 3);
    wr(A_EN, 1);
    int_irq = 4'b0001;
    chk_irq("R9 fall code rises", 1);
    rd(A_VEC, 0, "R9 vector");
    wr(A_EOI, 0);
    int_irq = 4'b0000;
    chk_irq("R9 no fall latch", 0);

    // R8 external trigger codes on source 4
    wr(A_CFG + 4, 8 + 1);
    wr(A_EN, 16);
    chk_irq("R8 low level active", 1);
    ext_irq = 4'b0001;
    chk_irq("R8 low level idle", 0);
    wr(A_CFG + 4, 24 + 1);
    chk_irq("R8 fall idle", 0);
    ext_irq = 4'b0000;
    chk_irq("R8 fall latched", 1);
    ext_irq = 4'b0001;
    chk_irq("R8 fall held", 1);
    rd(A_VEC, 4, "R8 fall vector");
    chk_irq("R8 fall cleared", 0);
    wr(A_EOI, 0);
    wr(A_CFG + 4, 16 + 1);
    ext_irq = 4'b0000;
    chk_irq("R8 rise no fall", 0);
    ext_irq = 4'b0001;
    chk_irq("R8 rise latched", 1);
    rd(A_VEC, 4, "R8 rise vector");
    wr(A_EOI, 0);
    wr(A_CFG + 4, 1);
    chk_irq("R8 high level", 1);
    ext_irq = 4'b0000;
    chk_irq("R8 high idle", 0);

    // R4 spurious
    rd(A_VEC, SPUR, "R4 spurious");
    chk_irq("R4 irq low", 0);

    // R10 fast path
    wr(A_EN, 0);
    fiq_req = 1;
    settle();
    chk("R10 fiq high", DW'(fiq_o), 1);
    chk("R10 irq untouched", DW'(irq_o), 0);
    fiq_req = 0;
    settle();
    chk("R10 fiq low", DW'(fiq_o), 0);

    settle();
    chk("pending reads drained", DW'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule